// File: doc/BRIEF.md
# Resume PHY Packet Decoder

This block examines each two-quadlet PHY packet that arrives on a receive interface and decides whether the packet is a resume command. A resume command is a broadcast with no reply. Every node that sees one acts on it, whatever node identifier the packet carries. When the command is well formed, the block gives a single-cycle resume pulse to each local port that is both connected and suspended at the moment the packet arrives. That pulse has the same effect as setting the port's resume variable true. Ports that are not both connected and suspended get nothing.

The first quadlet is read MSB first. Bits [31:30] are a lead code that must be `00`. Bits [29:24] hold the node identifier, which the decoder does not use. Bits [23:22] form a gap that must be zero. Bits [21:18] hold the extended type, and the value `4'hF` marks a resume command. Bits [17:0] are a tail that must be zero. The second quadlet must be the bitwise inverse of the first. A packet is *claimed* when its lead code is `00` and its type is `4'hF`. Any other packet is left for other decoders and does not affect this block. A claimed packet that fails the gap, tail or inverse check is rejected. A rejected packet raises the error flag and resumes no port.

The control logic is a three-state machine. `ST_IDLE` means no result is being shown. `ST_RESUMED` means a good claimed packet was seen on the previous edge. `ST_REJECTED` means a bad claimed packet was seen on the previous edge. All transitions are taken from any state at each clock edge:
- `GO_RESUME` leads to `ST_RESUMED` on a strobe that carries a good claimed packet.
- `GO_REJECT` leads to `ST_REJECTED` on a strobe that carries a bad claimed packet.
- `GO_IDLE` leads to `ST_IDLE` when there is no strobe, or when the strobe carries an unclaimed packet.

Top module: `resume_pkt_decoder`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `port_resume_o`, `resume_valid_o` and `pkt_error_o` are all zero, even if a valid packet is being strobed.
- R2: A strobed packet whose bits [31:30] are not `00`, or whose bits [21:18] are not `4'hF`, is unclaimed and produces no resume pulse and no error.
- R3: A claimed packet whose second quadlet differs from the bitwise inverse of the first in any bit raises `pkt_error_o` for one cycle and resumes no port.
- R4: A claimed packet with any bit of [23:22] or [17:0] set raises `pkt_error_o` for one cycle and resumes no port, even when the inverse check passes.
- R5: A good claimed packet strobed at edge N causes `resume_valid_o` to be high after edge N, with `port_resume_o` equal to `port_connected_i & port_suspended_i` as sampled at edge N.
- R6: Bits [29:24] of the first quadlet have no effect on the outcome.
- R7: Every result (resume pulse, valid flag, error flag) lasts exactly one cycle unless the next strobe produces a result of its own.
- R8: Strobes on consecutive cycles each produce their own result in the following cycle, each using the port status of its own cycle.
- R9: With `pkt_valid_i` low, changes on the packet or status inputs produce no output activity.
- R10: `resume_valid_o` and `pkt_error_o` are never high together, and `port_resume_o` is non-zero only while `resume_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pkt_valid_i | input | 1 | Packet strobe, one cycle per packet |
| pkt_q0_i | input | 32 | First quadlet |
| pkt_q1_i | input | 32 | Second quadlet (check quadlet) |
| port_connected_i | input | NUM_PORTS | Per-port connected status |
| port_suspended_i | input | NUM_PORTS | Per-port suspended status |
| port_resume_o | output | NUM_PORTS | Per-port one-cycle resume pulse |
| resume_valid_o | output | 1 | A good resume packet was accepted |
| pkt_error_o | output | 1 | A claimed packet was malformed |

## Verification
Good resume packets are sent with random node identifiers and random port status, so that the pulse vector shows it is the AND of the connected and suspended inputs and does not depend on the identifier. Single-bit flips of the check quadlet, including both end bits, are separated from gap and tail violations that carry a correct inverse, which shows that each check rejects the packet on its own. Unclaimed packets, such as those with another type, a non-zero lead code or random contents, are checked for silence and kept apart from errors. Back-to-back strobes and idle cycles with changing data show that each result belongs to exactly one strobe.

// File: rtl/resume_pkt_pkg.sv
package resume_pkt_pkg;

    localparam int QUAD_W = 32;
    localparam int ID_W   = 6;
    localparam int TYPE_W = 4;
    localparam int TAIL_W = QUAD_W - 2 - ID_W - 2 - TYPE_W;

    localparam logic [TYPE_W-1:0] EXT_TYPE_RESUME = 4'hF;

    // Layout of the first quadlet, MSB first.
    typedef struct packed {
        logic [1:0]        lead;
        logic [ID_W-1:0]   node_id;
        logic [1:0]        gap;
        logic [TYPE_W-1:0] ext_type;
        logic [TAIL_W-1:0] tail;
    } ext_quad0_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RESUMED  = 2'd1,
        ST_REJECTED = 2'd2
    } dec_state_e;

    typedef enum logic [1:0] {
        GO_IDLE   = 2'd0,
        GO_RESUME = 2'd1,
        GO_REJECT = 2'd2
    } dec_move_e;

endpackage

// File: rtl/resume_inverse_cmp.sv
module resume_inverse_cmp #(
    parameter int WIDTH   = 32,
    parameter int SLICE_W = 8
) (
    input  logic [WIDTH-1:0] word_a_i,
    input  logic [WIDTH-1:0] word_b_i,
    output logic             inverse_ok_o
);
    localparam int NUM_SLICES = (WIDTH + SLICE_W - 1) / SLICE_W;
    localparam int PAD_W      = NUM_SLICES * SLICE_W;

    logic [PAD_W-1:0]      a_pad;
    logic [PAD_W-1:0]      b_pad;
    logic [NUM_SLICES-1:0] slice_ok;

    // Padding is all-ones on one side and zero on the other, so it always matches.
    always_comb begin
        a_pad = '0;
        b_pad = '1;
        a_pad[WIDTH-1:0] = word_a_i;
        b_pad[WIDTH-1:0] = word_b_i;
    end

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        assign slice_ok[s] = ((a_pad[s*SLICE_W +: SLICE_W] ^ b_pad[s*SLICE_W +: SLICE_W])
                              == {SLICE_W{1'b1}});
    end

    assign inverse_ok_o = &slice_ok;

endmodule

// File: rtl/resume_field_check.sv
module resume_field_check
    import resume_pkt_pkg::*;
(
    input  logic [QUAD_W-1:0] quad0_i,
    input  logic [QUAD_W-1:0] quad1_i,
    output logic              claimed_o,
    output logic              good_o,
    output logic              bad_o
);
    ext_quad0_t hdr;
    logic       reserved_clear;
    logic       inverse_ok;

    assign hdr = ext_quad0_t'(quad0_i);

    resume_inverse_cmp #(
        .WIDTH   (QUAD_W),
        .SLICE_W (8)
    ) u_inv (
        .word_a_i     (quad0_i),
        .word_b_i     (quad1_i),
        .inverse_ok_o (inverse_ok)
    );

    always_comb begin
        claimed_o      = (hdr.lead == 2'b00) && (hdr.ext_type == EXT_TYPE_RESUME);
        reserved_clear = (hdr.gap == 2'b00) && (hdr.tail == '0);
        good_o         = claimed_o && reserved_clear && inverse_ok;
        bad_o          = claimed_o && !(reserved_clear && inverse_ok);
    end

    always_comb begin
        assert (!(good_o && bad_o));  // R10
    end

endmodule

// File: rtl/resume_port_gate.sv
module resume_port_gate #(
    parameter int NUM_PORTS = 3
) (
    input  logic [NUM_PORTS-1:0] connected_i,
    input  logic [NUM_PORTS-1:0] suspended_i,
    input  logic                 fire_i,
    output logic [NUM_PORTS-1:0] resume_d_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic eligible;
        assign eligible      = connected_i[p] & suspended_i[p];
        assign resume_d_o[p] = fire_i & eligible;
    end

endmodule

// File: rtl/resume_pkt_decoder.sv
module resume_pkt_decoder
    import resume_pkt_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 pkt_valid_i,
    input  logic [31:0]          pkt_q0_i,
    input  logic [31:0]          pkt_q1_i,
    input  logic [NUM_PORTS-1:0] port_connected_i,
    input  logic [NUM_PORTS-1:0] port_suspended_i,
    output logic [NUM_PORTS-1:0] port_resume_o,
    output logic                 resume_valid_o,
    output logic                 pkt_error_o
);
    dec_state_e           state_q;
    dec_state_e           state_d;
    dec_move_e            move;
    logic                 claimed;
    logic                 pkt_good;
    logic                 pkt_bad;
    logic [NUM_PORTS-1:0] resume_d;
    logic [NUM_PORTS-1:0] resume_q;

    resume_field_check u_check (
        .quad0_i   (pkt_q0_i),
        .quad1_i   (pkt_q1_i),
        .claimed_o (claimed),
        .good_o    (pkt_good),
        .bad_o     (pkt_bad)
    );

    resume_port_gate #(
        .NUM_PORTS (NUM_PORTS)
    ) u_gate (
        .connected_i (port_connected_i),
        .suspended_i (port_suspended_i),
        .fire_i      (pkt_valid_i && pkt_good),
        .resume_d_o  (resume_d)
    );

    // Transition selection.
    always_comb begin
        if (pkt_valid_i && pkt_good) begin
            move = GO_RESUME;
        end else if (pkt_valid_i && pkt_bad) begin
            move = GO_REJECT;
        end else begin
            move = GO_IDLE;
        end
        unique case (move)
            GO_RESUME: state_d = ST_RESUMED;
            GO_REJECT: state_d = ST_REJECTED;
            GO_IDLE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: the pulse vector is held only in the cycle after its strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            resume_q <= '0;
        end else begin
            resume_q <= resume_d;
        end
    end

    always_comb begin
        resume_valid_o = 1'b0;
        pkt_error_o    = 1'b0;
        port_resume_o  = '0;
        unique case (state_q)
            ST_RESUMED: begin
                resume_valid_o = 1'b1;
                port_resume_o  = resume_q;
            end
            ST_REJECTED: pkt_error_o = 1'b1;
            ST_IDLE:     ;
            default:     ;
        endcase
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(resume_valid_o && pkt_error_o));  // R10
    AST_PULSE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (port_resume_o != '0) |-> resume_valid_o);  // R10
    AST_QUIET_AFTER_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pkt_valid_i |=> (!resume_valid_o && !pkt_error_o && port_resume_o == '0));  // R7
    AST_ONLY_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_i |=> ((port_resume_o & ~$past(port_connected_i & port_suspended_i)) == '0));  // R5
    AST_ERR_FROM_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_valid_i && claimed && !pkt_good) |=> (pkt_error_o && port_resume_o == '0));  // R3
    AST_UNCLAIMED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkt_valid_i && !claimed) |=> (!pkt_error_o && !resume_valid_o));  // R2

endmodule

// File: tb/resume_pkt_decoder_tb_top.sv
module resume_pkt_decoder_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  NP         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pv = 1'b0;
    logic [31:0]   q0 = '0;
    logic [31:0]   q1 = '0;
    logic [NP-1:0] conn = '0;
    logic [NP-1:0] susp = '0;
    logic [NP-1:0] res;
    logic          vld;
    logic          err;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resume_pkt_decoder #(.NUM_PORTS(NP)) dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .pkt_valid_i      (pv),
        .pkt_q0_i         (q0),
        .pkt_q1_i         (q1),
        .port_connected_i (conn),
        .port_suspended_i (susp),
        .port_resume_o    (res),
        .resume_valid_o   (vld),
        .pkt_error_o      (err)
    );

    function automatic logic [31:0] mk_resume(input logic [5:0] id);
        return {2'b00, id, 2'b00, 4'hF, 18'h0};
    endfunction

    // Model from the requirements: {valid, error, pulse vector}.
    function automatic logic [NP+1:0] model(input logic v, input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [NP-1:0] c, input logic [NP-1:0] s);
        logic claim, bad, good;
        claim = v && (a[31:30] == 2'b00) && (a[21:18] == 4'hF);
        bad   = claim && ((b != ~a) || (a[23:22] != 2'b00) || (a[17:0] != 18'h0));
        good  = claim && !bad;
        return {good, bad, good ? (c & s) : {NP{1'b0}}};
    endfunction

    task automatic check(input string tag, input logic [NP+1:0] exp);
        vectors++;
        if ({vld, err, res} !== exp) begin
            fails++;
            $display("FAIL %s: got valid=%b err=%b resume=%b, expected valid=%b err=%b resume=%b",
                     tag, vld, err, res, exp[NP+1], exp[NP], exp[NP-1:0]);
        end
    endtask

    task automatic apply(input string tag, input logic v, input logic [31:0] a,
                         input logic [31:0] b, input logic [NP-1:0] c, input logic [NP-1:0] s);
        logic [NP+1:0] exp;
        @(negedge clk);
        pv = v; q0 = a; q1 = b; conn = c; susp = s;
        exp = model(v, a, b, c, s);
        @(posedge clk);
        #1;
        check(tag, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'h1394_5EED));

        // R1: reset dominates a valid strobe.
        pv = 1'b1; q0 = mk_resume(6'h05); q1 = ~mk_resume(6'h05); conn = '1; susp = '1;
        repeat (3) @(posedge clk);
        #1; check("R1 in reset", '0);
        @(negedge clk); rst_n = 1'b1; pv = 1'b0;
        @(posedge clk); #1; check("R1 first edge after reset", '0);

        // R5: all eligible, partial, none.
        apply("R5 all ports", 1, mk_resume(6'h01), ~mk_resume(6'h01), 3'b111, 3'b111);
        apply("R5 mixed status", 1, mk_resume(6'h02), ~mk_resume(6'h02), 3'b011, 3'b110);
        apply("R5 none eligible", 1, mk_resume(6'h03), ~mk_resume(6'h03), 3'b101, 3'b010);
        // R6: node identifier extremes.
        apply("R6 id 0", 1, mk_resume(6'h00), ~mk_resume(6'h00), 3'b111, 3'b101);
        apply("R6 id 3F", 1, mk_resume(6'h3F), ~mk_resume(6'h3F), 3'b111, 3'b101);
        // R7: the pulse lasts one cycle.
        apply("R7 idle after pulse", 0, mk_resume(6'h3F), ~mk_resume(6'h3F), 3'b111, 3'b111);
        // R3: inverse failures at both ends.
        apply("R3 bit0 flip", 1, mk_resume(6'h09), ~mk_resume(6'h09) ^ 32'h1, 3'b111, 3'b111);
        apply("R3 bit31 flip", 1, mk_resume(6'h09), ~mk_resume(6'h09) ^ 32'h8000_0000, 3'b111, 3'b111);
        apply("R7 error one cycle", 0, '0, '0, 3'b111, 3'b111);
        // R4: reserved bits set with a correct inverse.
        a = mk_resume(6'h11) | 32'h0040_0000;
        apply("R4 gap bit", 1, a, ~a, 3'b111, 3'b111);
        a = mk_resume(6'h11) | 32'h0000_0001;
        apply("R4 tail bit", 1, a, ~a, 3'b111, 3'b111);
        // R2: unclaimed packets.
        a = {2'b00, 6'h07, 2'b00, 4'hE, 18'h0};
        apply("R2 other type", 1, a, ~a, 3'b111, 3'b111);
        a = mk_resume(6'h07) | 32'h4000_0000;
        apply("R2 lead code", 1, a, ~a, 3'b111, 3'b111);
        // R9: no strobe with valid-looking data.
        apply("R9 no strobe", 0, mk_resume(6'h04), ~mk_resume(6'h04), 3'b111, 3'b111);
        // R8: back-to-back strobes, different status.
        apply("R8 first", 1, mk_resume(6'h0A), ~mk_resume(6'h0A), 3'b001, 3'b111);
        apply("R8 second", 1, mk_resume(6'h0B), ~mk_resume(6'h0B), 3'b110, 3'b111);
        apply("R8 then error", 1, mk_resume(6'h0B), mk_resume(6'h0B), 3'b111, 3'b111);
        apply("R8 then good", 1, mk_resume(6'h0C), ~mk_resume(6'h0C), 3'b010, 3'b010);

        // Random mix; R10 is covered by every comparison of both flags.
        for (int i = 0; i < 3000; i++) begin
            int unsigned kind;
            logic [31:0] r;
            logic [NP-1:0] c, s;
            kind = $urandom % 6;
            r = mk_resume(6'($urandom));
            c = NP'($urandom);
            s = NP'($urandom);
            case (kind)
                0: apply("R5 random good", 1, r, ~r, c, s);
                1: apply("R3 random flip", 1, r, ~r ^ (32'h1 << ($urandom % 32)), c, s);
                2: begin
                    r = r | (($urandom % 2 == 0) ? (32'h1 << ($urandom % 18))
                                                 : (32'h1 << (22 + $urandom % 2)));
                    apply("R4 random reserved", 1, r, ~r, c, s);
                end
                3: begin
                    r[21:18] = 4'($urandom % 15);
                    apply("R2 random type", 1, r, ~r, c, s);
                end
                4: apply("R9 random idle", 0, $urandom, $urandom, c, s);
                default: apply("R10 random garbage", 1, $urandom, $urandom, c, s);
            endcase
        end
        finish_run();
    end

endmodule